// File: doc/BRIEF.md
# Dual-Sum Lookahead Adder Slice

This block is one r-bit slice of an end-around-carry modular adder. It takes two r-bit operand slices and, with no clock and no state, works out both candidate sums at once: one for an incoming carry of 0 and one for an incoming carry of 1. The surrounding adder does not know the true incoming carry until a circular carry network has settled, so both candidates are ready early and a later multiplexer picks one.

The slice also exports a block generate and a block propagate bit. The external circular carry network uses these to form the carry into every slice, including the carry that wraps from the top slice back to the bottom one. Internal carries come from a parallel-prefix lookahead tree rather than a ripple chain. The block propagate can be built as the AND of the bitwise XORs (the default) or as the AND of the bitwise ORs. A parameter picks the form.

Choosing between the two sums, the circular carry logic and any special handling of a zero operand all lie outside this block.

Top module: `dual_sum_cla_slice`

## Requirements
- R1: `sum_c0_o` equals (`a_i` + `b_i`) modulo 2^W for every operand pair.
- R2: `sum_c1_o` equals (`a_i` + `b_i` + 1) modulo 2^W for every operand pair.
- R3: `blk_gen_o` is 1 exactly when `a_i` + `b_i` is at least 2^W, that is, when the slice produces a carry out with an incoming carry of 0.
- R4: With the XOR propagate form (`PROP_FORM` = `PROP_XOR`, the default), `blk_prop_o` is 1 exactly when `a_i` XOR `b_i` is all ones, which is when `a_i` + `b_i` = 2^W − 1.
- R5: With the OR propagate form (`PROP_FORM` = `PROP_OR`), `blk_prop_o` is 1 exactly when `a_i` OR `b_i` is all ones.
- R6: For either propagate form, `blk_gen_o` OR `blk_prop_o` is 1 exactly when `a_i` + `b_i` + 1 is at least 2^W, that is, when the slice produces a carry out with an incoming carry of 1.
- R7: R1 to R4 hold for any slice width W of 2 or more, including the cases where a carry travels from bit 0 to bit W−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand slice |
| b_i | input | W | Second operand slice |
| sum_c0_o | output | W | Candidate sum assuming incoming carry 0 |
| sum_c1_o | output | W | Candidate sum assuming incoming carry 1 |
| blk_gen_o | output | 1 | Block generate: a carry leaves the slice whatever the incoming carry |
| blk_prop_o | output | 1 | Block propagate: an incoming carry passes through the slice |

## Verification
The hardest case is the full propagate chain. Here the operand XOR is all ones, so an incoming carry of 1 must ripple through every lookahead level and both candidate sums differ in every bit. For the 4-bit slice, the stimulus sweeps every operand pair on both propagate forms, so every chain length and every generate/propagate overlap occurs. For an 8-bit slice, directed vectors build all-ones XOR patterns, a carry generated only at bit 0 that has to cross the whole slice, and the all-ones and all-zero operands.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Form of the block propagate term exported to the circular carry network
  typedef enum logic {
    PROP_XOR = 1'b0,  // AND of operand XORs: carry-in passes, never also generated
    PROP_OR  = 1'b1   // AND of operand ORs: cheaper transfer term, may overlap generate
  } prop_form_e;
endpackage

// File: rtl/dsc_bit_cell.sv
module dsc_bit_cell (
  input  logic a_i,
  input  logic b_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;

  // R4: a bit cannot both generate and (XOR-)propagate
  always_comb begin
    assert_bit_gp_excl_R4: assert (!(g_o && p_o))
      else $error("bit generate and propagate both set");
  end
endmodule

// File: rtl/dsc_prefix_tree.sv
module dsc_prefix_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] grp_g_o,  // generate of bits [i:0]
  output logic [W-1:0] grp_p_o   // propagate of bits [i:0]
);
  localparam int LV = (W > 1) ? $clog2(W) : 1;

  logic [LV:0][W-1:0] gl;
  logic [LV:0][W-1:0] pl;

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign gl[k+1][i] = gl[k][i] | (pl[k][i] & gl[k][i-D]);
        assign pl[k+1][i] = pl[k][i] & pl[k][i-D];
      end else begin : g_pass
        assign gl[k+1][i] = gl[k][i];
        assign pl[k+1][i] = pl[k][i];
      end
    end
  end

  assign grp_g_o = gl[LV];
  assign grp_p_o = pl[LV];

  // R3: with XOR propagates, a group never both generates and propagates
  always_comb begin
    assert_grp_excl_R3: assert ((grp_g_o & grp_p_o) == '0)
      else $error("group generate and propagate overlap");
  end
endmodule

// File: rtl/dsc_carry_pair.sv
module dsc_carry_pair #(
  parameter int W = 4
) (
  input  logic [W-1:0] grp_g_i,
  input  logic [W-1:0] grp_p_i,
  output logic [W-1:0] c0_o,  // carry into each bit, incoming carry 0
  output logic [W-1:0] c1_o   // carry into each bit, incoming carry 1
);
  assign c0_o[0] = 1'b0;
  assign c1_o[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : g_cin
    assign c0_o[i] = grp_g_i[i-1];
    assign c1_o[i] = grp_g_i[i-1] | grp_p_i[i-1];
  end

  // R2: raising the incoming carry can only add carries, never remove them
  always_comb begin
    assert_carry_mono_R2: assert ((c0_o & ~c1_o) == '0)
      else $error("carry with cin=0 set where cin=1 carry clear");
  end
endmodule

// File: rtl/dual_sum_cla_slice.sv
module dual_sum_cla_slice #(
  parameter int                  W         = 4,
  parameter dsc_pkg::prop_form_e PROP_FORM = dsc_pkg::PROP_XOR
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_c0_o,
  output logic [W-1:0] sum_c1_o,
  output logic         blk_gen_o,
  output logic         blk_prop_o
);
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_p;
  logic [W-1:0] grp_g;
  logic [W-1:0] grp_p;
  logic [W-1:0] cin0;
  logic [W-1:0] cin1;
  logic [W-1:0] sum_diff;

  for (genvar i = 0; i < W; i++) begin : g_cell
    dsc_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .g_o (bit_g[i]),
      .p_o (bit_p[i])
    );
  end

  dsc_prefix_tree #(.W(W)) u_tree (
    .g_i     (bit_g),
    .p_i     (bit_p),
    .grp_g_o (grp_g),
    .grp_p_o (grp_p)
  );

  dsc_carry_pair #(.W(W)) u_carry (
    .grp_g_i (grp_g),
    .grp_p_i (grp_p),
    .c0_o    (cin0),
    .c1_o    (cin1)
  );

  assign sum_c0_o  = bit_p ^ cin0;
  assign sum_c1_o  = bit_p ^ cin1;
  assign blk_gen_o = grp_g[W-1];
  assign sum_diff  = sum_c0_o ^ sum_c1_o;

  if (PROP_FORM == dsc_pkg::PROP_OR) begin : g_prop_or
    assign blk_prop_o = &(a_i | b_i);
    // R5: OR-form propagate covers every case the XOR form flags
    always_comb begin
      assert_or_covers_xor_R5: assert (!grp_p[W-1] || blk_prop_o)
        else $error("OR propagate clear while XOR propagate set");
    end
  end else begin : g_prop_xor
    assign blk_prop_o = grp_p[W-1];
    // R4: XOR-form block propagate and block generate are exclusive
    always_comb begin
      assert_blk_excl_R4: assert (!(blk_gen_o && blk_prop_o))
        else $error("block generate and XOR propagate both set");
    end
  end

  // R1/R2: the two candidates differ in a contiguous run of low bits
  always_comb begin
    assert_sum_run_R1: assert (sum_diff[0] && ((sum_diff & (sum_diff + 1'b1)) == '0))
      else $error("candidate sums do not differ by a low carry run");
    assert_sum_step_R2: assert (sum_c1_o == sum_c0_o + 1'b1)
      else $error("cin=1 sum is not cin=0 sum plus one");
  end
endmodule

// File: tb/test_dual_sum_cla_slice.sv
module test_dual_sum_cla_slice;
  localparam int WN = 4;
  localparam int WW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [WN-1:0] a4, b4;
  logic [WN-1:0] s0x, s1x, s0o, s1o;
  logic gx, px, go, po;
  logic [WW-1:0] a8, b8, s08, s18;
  logic g8, p8;

  dual_sum_cla_slice #(.W(WN), .PROP_FORM(dsc_pkg::PROP_XOR)) i_dual_sum_cla_slice (
    .a_i(a4), .b_i(b4), .sum_c0_o(s0x), .sum_c1_o(s1x), .blk_gen_o(gx), .blk_prop_o(px));

  dual_sum_cla_slice #(.W(WN), .PROP_FORM(dsc_pkg::PROP_OR)) i_dual_sum_cla_slice_or (
    .a_i(a4), .b_i(b4), .sum_c0_o(s0o), .sum_c1_o(s1o), .blk_gen_o(go), .blk_prop_o(po));

  dual_sum_cla_slice #(.W(WW)) i_dual_sum_cla_slice_w8 (
    .a_i(a8), .b_i(b8), .sum_c0_o(s08), .sum_c1_o(s18), .blk_gen_o(g8), .blk_prop_o(p8));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s a4=%0h b4=%0h a8=%0h b8=%0h actual=%0h expected=%0h",
               req, a4, b4, a8, b8, act, exp);
    end
  endtask

  // Checks both narrow instances against arithmetic on wide integers
  task automatic chk_narrow();
    int sum = int'(a4) + int'(b4);
    int e0 = sum % (1 << WN);
    int e1 = (sum + 1) % (1 << WN);
    int eg = (sum >= (1 << WN)) ? 1 : 0;
    int ec1 = (sum + 1 >= (1 << WN)) ? 1 : 0;
    int epx = ((a4 ^ b4) == {WN{1'b1}}) ? 1 : 0;
    int epo = ((a4 | b4) == {WN{1'b1}}) ? 1 : 0;
    chk(int'(s0x) == e0, "R1", int'(s0x), e0);
    chk(int'(s1x) == e1, "R2", int'(s1x), e1);
    chk(int'(gx) == eg, "R3", int'(gx), eg);
    chk(int'(px) == epx, "R4", int'(px), epx);
    chk(int'(gx | px) == ec1, "R6 xor form", int'(gx | px), ec1);
    chk(int'(po) == epo, "R5", int'(po), epo);
    chk(int'(go | po) == ec1, "R6 or form", int'(go | po), ec1);
    chk(int'(s0o) == e0 && int'(s1o) == e1 && int'(go) == eg, "R1 R2 R3 or form",
        int'({s1o, s0o}), (e1 << WN) | e0);
  endtask

  task automatic apply_narrow(input logic [WN-1:0] a, input logic [WN-1:0] b);
    @(posedge clk);
    a4 = a; b4 = b;
    @(negedge clk);
    chk_narrow();
  endtask

  task automatic apply_wide(input logic [WW-1:0] a, input logic [WW-1:0] b);
    int sum;
    int ep;
    @(posedge clk);
    a8 = a; b8 = b;
    @(negedge clk);
    sum = int'(a8) + int'(b8);
    ep = ((a8 ^ b8) == {WW{1'b1}}) ? 1 : 0;
    chk(int'(s08) == sum % (1 << WW), "R7 R1", int'(s08), sum % (1 << WW));
    chk(int'(s18) == (sum + 1) % (1 << WW), "R7 R2", int'(s18), (sum + 1) % (1 << WW));
    chk(int'(g8) == ((sum >= (1 << WW)) ? 1 : 0), "R7 R3", int'(g8), (sum >= (1 << WW)) ? 1 : 0);
    chk(int'(p8) == ep, "R7 R4", int'(p8), ep);
  endtask

  // Zero operands first: sums 0 and 1, no generate, no propagate
  task automatic t_zero();
    apply_narrow('0, '0);
    apply_wide('0, '0);
  endtask

  // Every 4-bit operand pair on both propagate forms: R1..R6
  task automatic t_exhaustive();
    for (int a = 0; a < (1 << WN); a++)
      for (int b = 0; b < (1 << WN); b++)
        apply_narrow(a[WN-1:0], b[WN-1:0]);
  endtask

  // R7: 8-bit corner cases, long propagate chains and a bit-0-only generate
  task automatic t_wide_corners();
    apply_wide(8'hFF, 8'h00);
    apply_wide(8'hAA, 8'h55);
    apply_wide(8'hFF, 8'hFF);
    apply_wide(8'hFF, 8'h01);
    apply_wide(8'hFE, 8'h01);
    apply_wide(8'h81, 8'h7F);
    apply_wide(8'h80, 8'h80);
    apply_wide(8'h7F, 8'h00);
    apply_wide(8'h0F, 8'hF0);
    apply_wide(8'h01, 8'h01);
  endtask

  initial begin
    a4 = '0; b4 = '0; a8 = '0; b8 = '0;
    t_zero();
    t_exhaustive();
    t_wide_corners();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule